// File: doc/BRIEF.md
# Serial Controller Byte Buffer Pair with Stalling Bus Access

This block sits between a 32-bit peripheral bus and the shift engine of a two-wire serial controller. It holds two small first-in first-out buffers of two bytes each. One buffer carries bytes out to the serial side. The other carries received bytes in.

On the transmit side, the bus either pushes one byte or writes a 16-bit halfword. A halfword is split into two ordered bytes and fills the buffer in one access. On the receive side, each bus read pops exactly one byte.

The bus is never refused. An access that cannot finish yet raises a wait output combinationally. The bus holds the request steady until the wait output drops, and the access completes at the first rising edge where the request is high and wait is low. Each buffer reports its fill level on a 2-bit status field. The shift engine sees only a pop port on the transmit buffer and a push port on the receive buffer.

Top module: `twi_byte_fifo`

## Requirements
- R1: An 8-bit transmit write (`tx_wide`=0) pushes `tx_wdata[7:0]` as one byte. `tx_wait` is high only while the transmit buffer holds two bytes.
- R2: A 16-bit transmit write (`tx_wide`=1) into an empty buffer completes without waiting and leaves the buffer full. The serial side then pops `tx_wdata[7:0]` first and `tx_wdata[15:8]` second.
- R3: A 16-bit transmit write holds `tx_wait` high while the transmit buffer is not empty. It completes in the first cycle after both bytes have been popped.
- R4: A receive read returns the oldest stored byte in `rx_rdata[7:0]`, in first-in first-out order, with `rx_rdata[31:8]` zero.
- R5: A receive read on an empty buffer holds `rx_wait` high. It completes in the cycle after the first byte is pushed.
- R6: Each status field (`tx_level`, `rx_level`) encodes 00 for empty, 01 for one byte and 11 for two bytes, and never 10. The field reflects a completed access from the cycle after the access.
- R7: A serial push while the receive buffer is full, with no bus read completing in the same cycle, drops the byte and sets the sticky `rx_overflow` flag. A pulse on `ovf_clear` clears the flag. A new overflow in the same cycle as a clear leaves the flag set.
- R8: A transmit pop (`ser_tx_pop`) takes effect only when `ser_tx_valid` is high. A pop on an empty buffer leaves it empty. A byte push and a pop in the same cycle leave the fill level unchanged.
- R9: After reset, both levels are 00, `rx_overflow` is 0 and both wait outputs are low while no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_wr | input | 1 | Transmit write request, held until accepted |
| tx_wide | input | 1 | 1: 16-bit write, 0: 8-bit write |
| tx_wdata | input | 16 | Transmit write data |
| tx_wait | output | 1 | Transmit write must be held |
| rx_rd | input | 1 | Receive read request, held until accepted |
| rx_rdata | output | BUS_W | Receive read data, byte zero-extended |
| rx_wait | output | 1 | Receive read must be held |
| tx_level | output | 2 | Transmit fill status |
| rx_level | output | 2 | Receive fill status |
| rx_overflow | output | 1 | Sticky receive overflow flag |
| ovf_clear | input | 1 | Clears the overflow flag |
| ser_tx_pop | input | 1 | Serial side takes the head transmit byte |
| ser_tx_data | output | 8 | Head transmit byte |
| ser_tx_valid | output | 1 | Transmit buffer holds at least one byte |
| ser_rx_push | input | 1 | Serial side delivers a received byte |
| ser_rx_data | input | 8 | Received byte |

## Verification
A corrupted read or write pointer shows as swapped or repeated bytes on `ser_tx_data` or `rx_rdata` at the very next pop. The directed tests therefore read out every byte they store and compare its order. A wrong fill count shows on the level field one cycle after the access that corrupted it. It also shows the same cycle on the wait outputs, because those are decoded from the count. For that reason the tests sample both the level and the wait after every access, including a held halfword write and a held read while the other side drains or fills.

// File: rtl/twi_byte_fifo.sv
module twi_byte_fifo #(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_wr,
  input  logic             tx_wide,
  input  logic [15:0]      tx_wdata,
  output logic             tx_wait,
  input  logic             rx_rd,
  output logic [BUS_W-1:0] rx_rdata,
  output logic             rx_wait,
  output logic [1:0]       tx_level,
  output logic [1:0]       rx_level,
  output logic             rx_overflow,
  input  logic             ovf_clear,
  input  logic             ser_tx_pop,
  output logic [7:0]       ser_tx_data,
  output logic             ser_tx_valid,
  input  logic             ser_rx_push,
  input  logic [7:0]       ser_rx_data
);
  localparam int PAD_W = BUS_W - 8;

  logic [7:0] tx_mem [0:1];
  logic       tx_rp, tx_wp;
  logic [1:0] tx_cnt;
  logic [7:0] rx_mem [0:1];
  logic       rx_rp, rx_wp;
  logic [1:0] rx_cnt;

  wire tx_full  = tx_cnt == 2'd2;
  wire tx_empty = tx_cnt == 2'd0;
  wire rx_full  = rx_cnt == 2'd2;
  wire rx_empty = rx_cnt == 2'd0;

  assign tx_wait = tx_wr && (tx_wide ? !tx_empty : tx_full);
  assign rx_wait = rx_rd && rx_empty;

  wire tx_take  = tx_wr && !tx_wait;
  wire tx_byte  = tx_take && !tx_wide;
  wire tx_pair  = tx_take && tx_wide;
  wire tx_pop   = ser_tx_pop && !tx_empty;
  wire rd_take  = rx_rd && !rx_wait;
  wire rx_put   = ser_rx_push && (!rx_full || rd_take);
  wire rx_drop  = ser_rx_push && !rx_put;

  assign tx_level     = {tx_cnt[1], tx_cnt[1] | tx_cnt[0]};
  assign rx_level     = {rx_cnt[1], rx_cnt[1] | rx_cnt[0]};
  assign ser_tx_data  = tx_mem[tx_rp];
  assign ser_tx_valid = !tx_empty;
  assign rx_rdata     = {{PAD_W{1'b0}}, rx_mem[rx_rp]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_mem[0] <= '0;
      tx_mem[1] <= '0;
    end else if (tx_pair) begin
      tx_mem[tx_wp]  <= tx_wdata[7:0];
      tx_mem[~tx_wp] <= tx_wdata[15:8];
    end else if (tx_byte) begin
      tx_mem[tx_wp]  <= tx_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_rp  <= 1'b0;
      tx_wp  <= 1'b0;
      tx_cnt <= 2'd0;
    end else begin
      if (tx_byte) tx_wp <= ~tx_wp;
      if (tx_pop)  tx_rp <= ~tx_rp;
      if (tx_pair)                tx_cnt <= 2'd2;
      else if (tx_byte && !tx_pop) tx_cnt <= tx_cnt + 2'd1;
      else if (!tx_byte && tx_pop) tx_cnt <= tx_cnt - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_mem[0] <= '0;
      rx_mem[1] <= '0;
    end else if (rx_put) begin
      rx_mem[rx_wp] <= ser_rx_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_rp       <= 1'b0;
      rx_wp       <= 1'b0;
      rx_cnt      <= 2'd0;
      rx_overflow <= 1'b0;
    end else begin
      if (rx_put)  rx_wp <= ~rx_wp;
      if (rd_take) rx_rp <= ~rx_rp;
      if (rx_put && !rd_take)      rx_cnt <= rx_cnt + 2'd1;
      else if (!rx_put && rd_take) rx_cnt <= rx_cnt - 2'd1;
      if (rx_drop)        rx_overflow <= 1'b1;
      else if (ovf_clear) rx_overflow <= 1'b0;
    end
  end
endmodule

module twi_byte_fifo_chk #(
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_wr,
  input logic             tx_wide,
  input logic [15:0]      tx_wdata,
  input logic             tx_wait,
  input logic             rx_rd,
  input logic [BUS_W-1:0] rx_rdata,
  input logic             rx_wait,
  input logic [1:0]       tx_level,
  input logic [1:0]       rx_level,
  input logic             rx_overflow,
  input logic             ovf_clear,
  input logic             ser_tx_pop,
  input logic [7:0]       ser_tx_data,
  input logic             ser_tx_valid,
  input logic             ser_rx_push,
  input logic [7:0]       ser_rx_data
);
  a_r1_full_holds_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && tx_level == 2'b11 |-> tx_wait);
  a_r2_pair_fills: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && tx_wide && !tx_wait |=> tx_level == 2'b11);
  a_r3_pair_waits: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && tx_wide && ser_tx_valid |-> tx_wait);
  a_r4_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && !rx_wait |-> rx_rdata[BUS_W-1:8] == '0);
  a_r5_empty_read_waits: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && rx_level == 2'b00 |-> rx_wait);
  a_r6_codes: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level != 2'b10 && rx_level != 2'b10);
  a_r6_read_drains: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && !rx_wait && !ser_rx_push && rx_level == 2'b01 |=> rx_level == 2'b00);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow && !ovf_clear |=> rx_overflow);
  a_r7_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ser_rx_push && rx_level == 2'b11 && !rx_rd |=> rx_overflow);
  a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    ser_tx_pop && !ser_tx_valid && !tx_wr |=> tx_level == 2'b00);
endmodule

bind twi_byte_fifo twi_byte_fifo_chk #(.BUS_W(BUS_W)) u_chk (.*);

// File: tb/twi_byte_fifo_bench.sv
`timescale 1ns/1ps
module twi_byte_fifo_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tx_wr = 0, tx_wide = 0;
  logic [15:0] tx_wdata = 0;
  logic        tx_wait;
  logic        rx_rd = 0;
  logic [31:0] rx_rdata;
  logic        rx_wait;
  logic [1:0]  tx_level, rx_level;
  logic        rx_overflow;
  logic        ovf_clear = 0;
  logic        ser_tx_pop = 0;
  logic [7:0]  ser_tx_data;
  logic        ser_tx_valid;
  logic        ser_rx_push = 0;
  logic [7:0]  ser_rx_data = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  twi_byte_fifo u_twi_byte_fifo (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_tx(input logic wide, input logic [15:0] d, output int waited);
    @(negedge clk); tx_wr = 1; tx_wide = wide; tx_wdata = d; waited = 0;
    #0.5;
    while (tx_wait) begin @(negedge clk); #0.5; waited++; end
    @(posedge clk); #0.5; tx_wr = 0;
  endtask

  task automatic bus_rx(output logic [31:0] d, output int waited);
    @(negedge clk); rx_rd = 1; waited = 0;
    #0.5;
    while (rx_wait) begin @(negedge clk); #0.5; waited++; end
    d = rx_rdata;
    @(posedge clk); #0.5; rx_rd = 0;
  endtask

  task automatic ser_pop(output logic [7:0] d);
    @(negedge clk); ser_tx_pop = 1; #0.5; d = ser_tx_data;
    @(posedge clk); #0.5; ser_tx_pop = 0;
  endtask

  task automatic ser_push(input logic [7:0] d);
    @(negedge clk); ser_rx_push = 1; ser_rx_data = d;
    @(posedge clk); #0.5; ser_rx_push = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R9 tx_level", tx_level, 2'b00);
    chk("R9 rx_level", rx_level, 2'b00);
    chk("R9 overflow", rx_overflow, 0);
    chk("R9 waits", {tx_wait, rx_wait}, 0);
  endtask

  task automatic t_byte_writes;
    int w; logic [7:0] b;
    bus_tx(0, 16'h00A1, w); chk("R1 no wait", w, 0);
    @(negedge clk); chk("R6 one byte", tx_level, 2'b01);
    bus_tx(0, 16'h00B2, w); chk("R1 second no wait", w, 0);
    @(negedge clk); chk("R6 full", tx_level, 2'b11);
    tx_wr = 1; tx_wide = 0; tx_wdata = 16'h00EE;
    repeat (3) begin #0.5; chk("R1 wait when full", tx_wait, 1); @(negedge clk); end
    tx_wr = 0;
    chk("R1 level kept", tx_level, 2'b11);
    ser_pop(b); chk("R1 first out", b, 8'hA1);
    ser_pop(b); chk("R1 second out", b, 8'hB2);
    @(negedge clk); chk("R8 drained", tx_level, 2'b00);
    ser_pop(b);
    @(negedge clk); chk("R8 empty pop ignored", tx_level, 2'b00);
    chk("R8 valid low", ser_tx_valid, 0);
  endtask

  task automatic t_wide;
    int w; logic [7:0] b;
    bus_tx(1, 16'h3C5A, w); chk("R2 no wait", w, 0);
    @(negedge clk); chk("R2 full", tx_level, 2'b11);
    ser_pop(b); chk("R2 low byte first", b, 8'h5A);
    ser_pop(b); chk("R2 high byte second", b, 8'h3C);
  endtask

  task automatic t_wide_stall;
    int w; logic [7:0] b, b1, b2;
    bus_tx(0, 16'h0011, w);
    fork
      bus_tx(1, 16'h7766, w);
      begin repeat (3) @(negedge clk); ser_pop(b); end
    join
    chk("R3 waited", w >= 3, 1);
    chk("R3 drained byte", b, 8'h11);
    @(negedge clk); chk("R3 full after", tx_level, 2'b11);
    ser_pop(b1); ser_pop(b2);
    chk("R3 order", {b1, b2}, 16'h6677);
  endtask

  task automatic t_same_cycle;
    int w; logic [7:0] b;
    bus_tx(0, 16'h0021, w);
    @(negedge clk); tx_wr = 1; tx_wide = 0; tx_wdata = 16'h0022; ser_tx_pop = 1;
    #0.5; b = ser_tx_data;
    @(posedge clk); #0.5; tx_wr = 0; ser_tx_pop = 0;
    chk("R8 popped old", b, 8'h21);
    @(negedge clk); chk("R8 level unchanged", tx_level, 2'b01);
    ser_pop(b); chk("R8 new byte", b, 8'h22);
  endtask

  task automatic t_rx;
    int w; logic [31:0] d;
    ser_push(8'h81); ser_push(8'h92);
    @(negedge clk); chk("R6 rx full", rx_level, 2'b11);
    bus_rx(d, w); chk("R4 oldest zero-ext", d, 32'h81);
    @(negedge clk); chk("R6 rx one", rx_level, 2'b01);
    bus_rx(d, w); chk("R4 next", d, 32'h92);
    @(negedge clk); chk("R6 rx empty", rx_level, 2'b00);
  endtask

  task automatic t_rx_stall;
    int w; logic [31:0] d;
    fork
      bus_rx(d, w);
      begin repeat (4) @(negedge clk); ser_push(8'hC3); end
    join
    chk("R5 waited", w >= 4, 1);
    chk("R5 data", d, 32'hC3);
    @(negedge clk); chk("R5 level after", rx_level, 2'b00);
  endtask

  task automatic t_ovf;
    int w; logic [31:0] d;
    ser_push(8'h01); ser_push(8'h02);
    @(negedge clk); chk("R7 no flag yet", rx_overflow, 0);
    ser_push(8'h03);
    @(negedge clk); chk("R7 flag set", rx_overflow, 1);
    chk("R7 level full", rx_level, 2'b11);
    bus_rx(d, w); chk("R7 first kept", d, 32'h01);
    bus_rx(d, w); chk("R7 dropped byte absent", d, 32'h02);
    @(negedge clk); chk("R7 sticky", rx_overflow, 1);
    ovf_clear = 1; @(posedge clk); #0.5; ovf_clear = 0;
    @(negedge clk); chk("R7 cleared", rx_overflow, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #0.5; rst_n = 1;
    t_reset();
    t_byte_writes();
    t_wide();
    t_wide_stall();
    t_same_cycle();
    t_rx();
    t_rx_stall();
    t_ovf();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule